// File: doc/BRIEF.md
# Serially Commanded 12-Bit Shared-Pin I/O Port

This block is a twelve-pin general-purpose digital port that is programmed entirely through 16-bit serial frames. Each frame carries a 4-bit opcode in its low nibble and a 12-bit payload above it. Three opcodes act on the port. One sets the direction of each pin. One loads the output latch. One samples the pin inputs back into the shift register, so that the host can clock them out while it sends the next frame. All other opcodes belong to neighbouring blocks, and the port ignores them.

The pads are modelled as three separate buses: output value, drive enable and input value. The upper eight pins share their pads with eight converter outputs, in reversed order. The block takes a high-impedance flag from each converter channel. For every shared pin, it raises a registered conflict flag whenever the pin is driven while its converter is also live.

The serial interface works in the system clock domain. `shift_i` is a one-cycle strobe per bit, and `load_i` is a one-cycle strobe that ends the frame and executes the opcode held in the register.

Top module: `shared_io_expander`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `pin_oe_o`, `pin_out_o`, `conflict_o` and `so_o` are all zero, so every pin is an undriven input.
- R2: On a clock edge where `shift_i` is 1 and `load_i` is 0, the 16-bit register shifts one place toward bit 0 and takes `sdi_i` into bit 15. `so_o` always shows bit 0. Sixteen shifts therefore place the first bit sent in bit 0. The opcode is bits 3..0 and the payload is bits 15..4.
- R3: A load with opcode 4'hD copies payload bits 15..4 into the output latch, with bit 4 going to pin 0 and bit 15 going to pin 11. `pin_out_o` shows the new value from the load edge onward.
- R4: A load with opcode 4'hF copies the payload into the direction register. A 1 drives the pin and a 0 makes it an input. `pin_oe_o` shows the direction register.
- R5: A load with opcode 4'hE writes the synchronised pin inputs into register bits 15..4 and leaves bits 3..0 unchanged. The next 16 shifts present bits 0 to 15 on `so_o` in that order.
- R6: A load with any other opcode leaves `pin_out_o` and `pin_oe_o` unchanged.
- R7: The capture sees a pin value only after it has been stable for at least two clock edges. A change that first appears in the cycle of the load is not captured.
- R8: When `load_i` and `shift_i` are 1 in the same cycle, the load executes on the unshifted register contents and the shift is dropped.
- R9: `conflict_o[k]` refers to pin 4+k. `ch_hiz_i[j]` refers to converter channel j, and channel j shares its pad with pin 11-j. One clock after its inputs, `conflict_o[k]` is 1 exactly when pin 4+k is driven and its channel's high-impedance flag is 0.
- R10: `pin_out_o` keeps the latch value whatever the direction, so the value on a pin does not depend on whether the data or the direction was written first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_i | input | 1 | One-cycle strobe per serial bit |
| sdi_i | input | 1 | Serial data bit |
| load_i | input | 1 | End-of-frame strobe; executes the opcode |
| so_o | output | 1 | Serial readback bit (register bit 0) |
| pin_in_i | input | 12 | Pad input values, asynchronous |
| pin_out_o | output | 12 | Pad output values |
| pin_oe_o | output | 12 | Pad drive enables |
| ch_hiz_i | input | 8 | Converter channel high-impedance flags, index j = channel j |
| conflict_o | output | 8 | Drive conflict per shared pin, index k = pin 4+k |

## Verification
Two pairs of events can fall on the same clock edge. The first is a capture load and a change on the pins. The bench changes the pins in the very cycle that carries the load strobe, and then expects the readback to hold the older, settled value. The second is a shift strobe and a load strobe. The bench raises both together and judges the result at the ports, in two ways: the readback must equal the unshifted capture, and a write made under the same collision must land in the output latch unchanged.

// File: rtl/ioexp_pkg.sv
package ioexp_pkg;
  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_PIN_WRITE   = 4'hD,
    OP_PIN_CAPTURE = 4'hE,
    OP_PIN_DIR     = 4'hF
  } op_e;
endpackage

// File: rtl/ioexp_sync.sv
module ioexp_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ioexp_shifter.sv
module ioexp_shifter #(
  parameter int FRAME_W = 16,
  parameter int OPC_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shift_en_i,
  input  logic                     sdi_i,
  input  logic                     cap_i,
  input  logic [FRAME_W-OPC_W-1:0] cap_data_i,
  output logic [FRAME_W-1:0]       sr_o
);
  logic [FRAME_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (cap_i) begin
      sr_q[FRAME_W-1:OPC_W] <= cap_data_i;
    end else if (shift_en_i) begin
      sr_q <= {sdi_i, sr_q[FRAME_W-1:1]};
    end
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/ioexp_port.sv
module ioexp_port
  import ioexp_pkg::*;
#(
  parameter int PIN_W    = 12,
  parameter int SHARED_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [OPC_W-1:0]    opc_i,
  input  logic [PIN_W-1:0]    data_i,
  input  logic [SHARED_W-1:0] ch_hiz_i,
  output logic [PIN_W-1:0]    out_o,
  output logic [PIN_W-1:0]    dir_o,
  output logic [SHARED_W-1:0] conflict_o
);
  localparam int BASE = PIN_W - SHARED_W;

  logic [PIN_W-1:0]    out_q, dir_q;
  logic [SHARED_W-1:0] clash, conflict_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      dir_q <= '0;
    end else if (load_i) begin
      if (opc_i == OP_PIN_WRITE) out_q <= data_i;
      if (opc_i == OP_PIN_DIR)   dir_q <= data_i;
    end
  end

  // shared pin BASE+k sits on the pad of channel SHARED_W-1-k
  for (genvar k = 0; k < SHARED_W; k++) begin : g_clash
    assign clash[k] = dir_q[BASE+k] & ~ch_hiz_i[SHARED_W-1-k];
  end

  always_ff @(posedge clk) begin
    if (rst) conflict_q <= '0;
    else     conflict_q <= clash;
  end

  assign out_o      = out_q;
  assign dir_o      = dir_q;
  assign conflict_o = conflict_q;
endmodule

// File: rtl/shared_io_expander.sv
module shared_io_expander
  import ioexp_pkg::*;
#(
  parameter int PIN_W       = 12,
  parameter int SHARED_W    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_i,
  input  logic                sdi_i,
  input  logic                load_i,
  output logic                so_o,
  input  logic [PIN_W-1:0]    pin_in_i,
  output logic [PIN_W-1:0]    pin_out_o,
  output logic [PIN_W-1:0]    pin_oe_o,
  input  logic [SHARED_W-1:0] ch_hiz_i,
  output logic [SHARED_W-1:0] conflict_o
);
  localparam int FRAME_W = PIN_W + OPC_W;

  logic [FRAME_W-1:0] sr_q;
  logic [PIN_W-1:0]   pin_sync;
  logic [OPC_W-1:0]   opc;
  logic               cap;

  assign opc = sr_q[OPC_W-1:0];
  assign cap = load_i && (opc == OP_PIN_CAPTURE);

  ioexp_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (pin_in_i),
    .q_o (pin_sync)
  );

  ioexp_shifter #(.FRAME_W(FRAME_W), .OPC_W(OPC_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .shift_en_i (shift_i & ~load_i),
    .sdi_i      (sdi_i),
    .cap_i      (cap),
    .cap_data_i (pin_sync),
    .sr_o       (sr_q)
  );

  ioexp_port #(.PIN_W(PIN_W), .SHARED_W(SHARED_W)) u_port (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .opc_i      (opc),
    .data_i     (sr_q[FRAME_W-1:OPC_W]),
    .ch_hiz_i   (ch_hiz_i),
    .out_o      (pin_out_o),
    .dir_o      (pin_oe_o),
    .conflict_o (conflict_o)
  );

  assign so_o = sr_q[0];
endmodule

// File: rtl/shared_io_expander_chk.sv
module shared_io_expander_chk #(
  parameter int PIN_W    = 12,
  parameter int SHARED_W = 8,
  parameter int FRAME_W  = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                shift_i,
  input logic                load_i,
  input logic                so_o,
  input logic [FRAME_W-1:0]  sr_q,
  input logic [PIN_W-1:0]    pin_out_o,
  input logic [PIN_W-1:0]    pin_oe_o,
  input logic [SHARED_W-1:0] conflict_o
);
  AST_SHIFT_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (shift_i && !load_i) |=> (so_o == $past(sr_q[1])));  // R2

  AST_OUT_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(pin_out_o));  // R3

  AST_DIR_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(pin_oe_o));  // R4

  AST_CAPTURE_KEEPS_OPC: assert property (@(posedge clk) disable iff (rst)
    load_i |=> $stable(sr_q[3:0]));  // R5

  AST_FOREIGN_OPC_INERT: assert property (@(posedge clk) disable iff (rst)
    (load_i && sr_q[3:2] != 2'b11) |=> ($stable(pin_oe_o) && $stable(pin_out_o)));  // R6

  AST_LOAD_BLOCKS_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (load_i && shift_i) |=> $stable(so_o));  // R8

  AST_CONFLICT_NEEDS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((conflict_o & ~$past(pin_oe_o[PIN_W-1 -: SHARED_W])) == '0));  // R9
endmodule

bind shared_io_expander shared_io_expander_chk #(
  .PIN_W(PIN_W), .SHARED_W(SHARED_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .shift_i    (shift_i),
  .load_i     (load_i),
  .so_o       (so_o),
  .sr_q       (sr_q),
  .pin_out_o  (pin_out_o),
  .pin_oe_o   (pin_oe_o),
  .conflict_o (conflict_o)
);

// File: tb/tb_shared_io_expander.sv
`timescale 1ns/1ps
module tb_shared_io_expander;
  logic        clk = 0;
  logic        rst = 1;
  logic        shift_i = 0, sdi_i = 0, load_i = 0;
  logic        so_o;
  logic [11:0] pin_in_i = '0;
  logic [11:0] pin_out_o, pin_oe_o;
  logic [7:0]  ch_hiz_i = 8'hFF;
  logic [7:0]  conflict_o;

  int checks = 0, errors = 0;
  logic [15:0] rb;

  always #4 clk = ~clk;

  shared_io_expander dut (
    .clk(clk), .rst(rst), .shift_i(shift_i), .sdi_i(sdi_i), .load_i(load_i),
    .so_o(so_o), .pin_in_i(pin_in_i), .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o),
    .ch_hiz_i(ch_hiz_i), .conflict_o(conflict_o)
  );

  // {frame, expected pin_out_o, expected pin_oe_o}
  localparam logic [39:0] VEC [6] = '{
    {16'hA5CD, 12'hA5C, 12'h000},
    {16'h0F3F, 12'hA5C, 12'h0F3},
    {16'h1230, 12'hA5C, 12'h0F3},
    {16'hFFFD, 12'hFFF, 12'h0F3},
    {16'hF00F, 12'hFFF, 12'hF00},
    {16'h000C, 12'hFFF, 12'hF00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic shift_word(input logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); sdi_i = w[i]; shift_i = 1;
    end
    @(negedge clk); shift_i = 0; sdi_i = 0;
  endtask

  task automatic pulse_load(input logic with_shift, input logic chg, input logic [11:0] np);
    @(negedge clk); load_i = 1; shift_i = with_shift; sdi_i = 1;
    if (chg) pin_in_i = np;
    @(negedge clk); load_i = 0; shift_i = 0; sdi_i = 0;
  endtask

  task automatic read_word(output logic [15:0] w);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); w[i] = so_o; sdi_i = 0; shift_i = 1;
    end
    @(negedge clk); shift_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 oe", 32'(pin_oe_o), 0);
    chk("R1 out", 32'(pin_out_o), 0);
    chk("R1 conflict", 32'(conflict_o), 0);
    chk("R1 so", 32'(so_o), 0);

    // R2: raw shifting, no load
    shift_word(16'hBEEF);
    read_word(rb);
    chk("R2 shift order", 32'(rb), 32'hBEEF);

    // R3 R4 R6 R10: table walk
    for (int v = 0; v < 6; v++) begin
      shift_word(VEC[v][39:24]);
      pulse_load(0, 0, 12'h000);
      chk("R3/R6/R10 pin_out table", 32'(pin_out_o), 32'(VEC[v][23:12]));
      chk("R4/R6 pin_oe table", 32'(pin_oe_o), 32'(VEC[v][11:0]));
    end

    // R9: pins 8..11 driven, reversed channel map
    @(negedge clk); ch_hiz_i = 8'h00;
    @(negedge clk); chk("R9 all live", 32'(conflict_o), 32'hF0);
    ch_hiz_i = 8'h01;
    @(negedge clk); chk("R9 ch0 hiz clears pin11", 32'(conflict_o), 32'h70);
    ch_hiz_i = 8'h80;
    @(negedge clk); chk("R9 ch7 hiz on undriven pin4", 32'(conflict_o), 32'hF0);
    ch_hiz_i = 8'hFF;
    @(negedge clk); chk("R9 all hiz", 32'(conflict_o), 32'h00);

    // R5: capture and readback
    pin_in_i = 12'h5A3;
    repeat (3) @(negedge clk);
    shift_word(16'h000E);
    pulse_load(0, 0, 12'h000);
    read_word(rb);
    chk("R5 capture readback", 32'(rb), 32'h5A3E);

    // R7: pin change in the load cycle is not captured
    shift_word(16'h000E);
    pulse_load(0, 1, 12'h3C1);
    read_word(rb);
    chk("R7 late change ignored", 32'(rb), 32'h5A3E);
    repeat (3) @(negedge clk);
    shift_word(16'h000E);
    pulse_load(0, 0, 12'h000);
    read_word(rb);
    chk("R7 settled change captured", 32'(rb), 32'h3C1E);

    // R8: shift strobe colliding with load
    shift_word(16'h000E);
    pulse_load(1, 0, 12'h000);
    read_word(rb);
    chk("R8 capture with shift", 32'(rb), 32'h3C1E);
    shift_word(16'h777D);
    pulse_load(1, 0, 12'h000);
    chk("R8 write with shift", 32'(pin_out_o), 32'h777);
    chk("R10 dir untouched by write", 32'(pin_oe_o), 32'hF00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule